// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table that sits in memory. A requester supplies the virtual address and the frame number of the top-level (master) table. The master table is pinned in physical memory, so its base needs no translation. The walker reads one word from the master table, and that word names the frame of a secondary table. It then reads one word from the secondary table, and that word names the physical frame. It returns the frame joined to the unchanged 12-bit page offset. If either entry is marked absent, it returns a fault tagged with the failing level.

The virtual address is split 10/10/12. Bits 31:22 index the master table. Bits 21:12 index the secondary table. Bits 11:0 are the byte offset inside a 4 KiB page. Each table fills exactly one page: 1024 entries of 4 bytes. An entry holds its present flag in bit 0 and a 20-bit frame number in bits 31:12.

The walk is run by a four-state machine:
- `ST_IDLE` moves to `ST_READ_MASTER` when a request is taken.
- `ST_READ_MASTER` moves to `ST_READ_SECONDARY` on a present master entry, or to `ST_DONE` on an absent one.
- `ST_READ_SECONDARY` moves to `ST_DONE` in both cases.
- `ST_DONE` returns to `ST_IDLE` when the requester acknowledges.

Each read state raises a memory request and holds it until it is accepted. The state then waits for the single response.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: On a successful walk, `rsp_paddr[11:0]` equals bits 11:0 of the virtual address.
- R3: The first memory read goes to address `{req_root, va[31:22], 2'b00}`.
- R4: The second memory read goes to address `{master_entry[31:12], va[21:12], 2'b00}`. It is issued only after a master entry with bit 0 set has been returned.
- R5: When both entries have bit 0 set, the response is `rsp_paddr = {secondary_entry[31:12], va[11:0]}` with `rsp_fault` = 0 and `rsp_level` = 2'b00, after exactly two memory reads.
- R6: When the master entry has bit 0 clear, the response has `rsp_fault` = 1 and `rsp_level` = 2'b01, after exactly one memory read.
- R7: When the secondary entry has bit 0 clear, the response has `rsp_fault` = 1 and `rsp_level` = 2'b10, after exactly two memory reads.
- R8: A request is taken only while `req_ready` is 1 (idle). A `req_valid` raised during a walk is ignored and does not change that walk's result.
- R9: `rsp_valid` stays 1 until `rsp_ack` is seen, and the response fields stay stable meanwhile. After the acknowledge, `req_ready` is 1 again.
- R10: A raised `mem_req_valid` stays up with a stable address until `mem_req_ready` accepts it. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker is idle and takes a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 20 | Frame number of the master table |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is returned |
| mem_rsp_data | input | 32 | Table entry word |
| rsp_valid | output | 1 | Translation result is available |
| rsp_paddr | output | 32 | Physical address (zero on a fault) |
| rsp_fault | output | 1 | Walk ended on an absent entry |
| rsp_level | output | 2 | 00 none, 01 master absent, 10 secondary absent |
| rsp_ack | input | 1 | Requester consumes the result |

## Verification
The hardest situation to reach from the ports is a read request that sits unaccepted across several cycles while a stray new translation request is also being driven. The address must not move, no second read may slip out, and the stray request must not disturb the walk in flight. The bench reaches this by gating the memory's accept line with a slow repeating pattern. During one walk it keeps `req_valid` high with a different address. It also delays the acknowledge for several cycles, to hold `ST_DONE` and watch the result stay frozen.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 10;
    localparam int ENT_LOG2  = 2;
    localparam int FRAME_W   = PA_W - OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_MASTER,
        ST_READ_SECONDARY,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'b00,
        FLT_MASTER    = 2'b01,
        FLT_SECONDARY = 2'b10
    } fault_lvl_e;
endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
    parameter int VA_W  = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [IDX_W-1:0] master_idx,
    output logic [IDX_W-1:0] second_idx,
    output logic [OFF_W-1:0] offset
);
    localparam int HI_LSB = VA_W - IDX_W;
    localparam int LO_LSB = OFF_W;

    assign master_idx = vaddr[VA_W-1:HI_LSB];
    assign second_idx = vaddr[LO_LSB+IDX_W-1:LO_LSB];
    assign offset     = vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int FRAME_W  = 20,
    parameter int IDX_W    = 10,
    parameter int ENT_LOG2 = 2
) (
    input  logic [FRAME_W-1:0]                  table_frame,
    input  logic [IDX_W-1:0]                    index,
    output logic [FRAME_W+IDX_W+ENT_LOG2-1:0]   entry_addr
);
    assign entry_addr = {table_frame, index, {ENT_LOG2{1'b0}}};
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int ENT_W   = 32,
    parameter int FRAME_W = 20
) (
    input  logic [ENT_W-1:0]   entry,
    output logic               present,
    output logic [FRAME_W-1:0] frame
);
    assign present = entry[0];
    assign frame   = entry[ENT_W-1:ENT_W-FRAME_W];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] req_root,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [PA_W-1:0]    mem_rsp_data,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_fault,
    output logic [1:0]         rsp_level,
    input  logic               rsp_ack
);
    walk_state_e        state_q, state_d;
    logic [VA_W-1:0]    va_q, va_d;
    logic [FRAME_W-1:0] root_q, root_d;
    logic [FRAME_W-1:0] sec_q, sec_d;
    logic               issued_q, issued_d;
    logic [PA_W-1:0]    paddr_q, paddr_d;
    logic               fault_q, fault_d;
    fault_lvl_e         lvl_q, lvl_d;

    logic [IDX_W-1:0]   idx_hi, idx_lo;
    logic [OFF_W-1:0]   pg_off;
    logic [FRAME_W-1:0] tbl_frame;
    logic [IDX_W-1:0]   tbl_idx;
    logic [PA_W-1:0]    ent_addr;
    logic               ent_present;
    logic [FRAME_W-1:0] ent_frame;
    logic               got_rsp;

    ptw_va_split #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
        .vaddr      (va_q),
        .master_idx (idx_hi),
        .second_idx (idx_lo),
        .offset     (pg_off)
    );

    assign tbl_frame = (state_q == ST_READ_SECONDARY) ? sec_q  : root_q;
    assign tbl_idx   = (state_q == ST_READ_SECONDARY) ? idx_lo : idx_hi;

    ptw_entry_addr #(.FRAME_W(FRAME_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)) u_addr (
        .table_frame (tbl_frame),
        .index       (tbl_idx),
        .entry_addr  (ent_addr)
    );

    ptw_entry_decode #(.ENT_W(PA_W), .FRAME_W(FRAME_W)) u_dec (
        .entry   (mem_rsp_data),
        .present (ent_present),
        .frame   (ent_frame)
    );

    assign got_rsp = issued_q && mem_rsp_valid;

    // Next-state and datapath update
    always_comb begin
        state_d  = state_q;
        va_d     = va_q;
        root_d   = root_q;
        sec_d    = sec_q;
        issued_d = issued_q;
        paddr_d  = paddr_q;
        fault_d  = fault_q;
        lvl_d    = lvl_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    va_d     = req_vaddr;
                    root_d   = req_root;
                    issued_d = 1'b0;
                    fault_d  = 1'b0;
                    lvl_d    = FLT_NONE;
                    paddr_d  = '0;
                    state_d  = ST_READ_MASTER;
                end
            end
            ST_READ_MASTER: begin
                if (mem_req_valid && mem_req_ready) issued_d = 1'b1;
                if (got_rsp) begin
                    issued_d = 1'b0;
                    if (ent_present) begin
                        sec_d   = ent_frame;
                        state_d = ST_READ_SECONDARY;
                    end else begin
                        fault_d = 1'b1;
                        lvl_d   = FLT_MASTER;
                        state_d = ST_DONE;
                    end
                end
            end
            ST_READ_SECONDARY: begin
                if (mem_req_valid && mem_req_ready) issued_d = 1'b1;
                if (got_rsp) begin
                    issued_d = 1'b0;
                    if (ent_present) begin
                        paddr_d = {ent_frame, pg_off};
                    end else begin
                        fault_d = 1'b1;
                        lvl_d   = FLT_SECONDARY;
                    end
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (rsp_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            va_q     <= '0;
            root_q   <= '0;
            sec_q    <= '0;
            issued_q <= 1'b0;
            paddr_q  <= '0;
            fault_q  <= 1'b0;
            lvl_q    <= FLT_NONE;
        end else begin
            state_q  <= state_d;
            va_q     <= va_d;
            root_q   <= root_d;
            sec_q    <= sec_d;
            issued_q <= issued_d;
            paddr_q  <= paddr_d;
            fault_q  <= fault_d;
            lvl_q    <= lvl_d;
        end
    end

    // Outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        rsp_valid     = 1'b0;
        mem_req_addr  = ent_addr;
        rsp_paddr     = paddr_q;
        rsp_fault     = fault_q;
        rsp_level     = lvl_q;
        unique case (state_q)
            ST_IDLE:           req_ready     = 1'b1;
            ST_READ_MASTER:    mem_req_valid = !issued_q;
            ST_READ_SECONDARY: mem_req_valid = !issued_q;
            ST_DONE:           rsp_valid     = 1'b1;
            default:           req_ready     = 1'b0;
        endcase
    end

    // Checks beside the logic they guard
    assert_idle_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req_valid));

    assert_hold_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_paddr)
                                     && $stable(rsp_fault) && $stable(rsp_level)));

    assert_hold_memreq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    assert_fault_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_level != 2'b00)));

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

    assert_master_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && $rose(mem_req_valid) && $past(req_ready))
            |-> (mem_req_addr == {root_q, va_q[VA_W-1:VA_W-IDX_W], {ENT_LOG2{1'b0}}}));
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [19:0] req_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_level;
    logic        rsp_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    logic       stall_en = 1'b0;
    logic [7:0] stall_cnt;
    logic [3:0] walk_reads;
    logic [31:0] rd_addr0, rd_addr1;

    localparam logic [19:0] ROOT = 20'h00010;

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] pa;
        logic        fault;
        logic [1:0]  lvl;
        logic [3:0]  reads;
        logic [31:0] sec_frame_base;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_5123, 32'hABCD_E123, 1'b0, 2'b00, 4'd2, 32'h0002_0000},
        '{32'h007F_FFFF, 32'h1234_5FFF, 1'b0, 2'b00, 4'd2, 32'h0002_0000},
        '{32'hFFC0_0000, 32'hFFFF_F000, 1'b0, 2'b00, 4'd2, 32'h0003_0000},
        '{32'h0080_0ABC, 32'h0000_0000, 1'b1, 2'b01, 4'd1, 32'h0000_0000},
        '{32'h0040_6777, 32'h0000_0000, 1'b1, 2'b10, 4'd2, 32'h0002_0000},
        '{32'h0000_0000, 32'h0000_0000, 1'b1, 2'b01, 4'd1, 32'h0000_0000}
    };

    ptw_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_level(rsp_level), .rsp_ack(rsp_ack)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] table_word(input logic [31:0] a);
        case (a)
            32'h0001_0004: return 32'h0002_0001;
            32'h0001_0FFC: return 32'h0003_0001;
            32'h0001_0008: return 32'h0004_0000;
            32'h0002_0014: return 32'hABCD_E001;
            32'h0002_0FFC: return 32'h1234_5003;
            32'h0002_0018: return 32'h5555_5000;
            32'h0003_0000: return 32'hFFFF_F001;
            default:       return 32'h0000_0000;
        endcase
    endfunction

    assign mem_req_ready = !stall_en || (stall_cnt % 8'd3 == 8'd2);

    // Memory model: one-cycle read latency, logs each walk's accepted addresses
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            stall_cnt     <= '0;
            walk_reads    <= '0;
            rd_addr0      <= '0;
            rd_addr1      <= '0;
        end else begin
            stall_cnt     <= stall_cnt + 8'd1;
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            mem_rsp_data  <= table_word(mem_req_addr);
            if (req_valid && req_ready) begin
                walk_reads <= '0;
            end else if (mem_req_valid && mem_req_ready) begin
                if (walk_reads == 4'd0) rd_addr0 <= mem_req_addr;
                else                    rd_addr1 <= mem_req_addr;
                walk_reads <= walk_reads + 4'd1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_tb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Starts a walk, optionally keeps a stray request driven, waits for the result
    task automatic run_walk(input logic [31:0] va, input bit stray);
        @(negedge clk);
        req_vaddr = va;
        req_root  = ROOT;
        req_valid = 1'b1;
        @(negedge clk);
        if (stray) begin
            req_vaddr = 32'hFFC0_0000;
            req_root  = 20'h00777;
            for (int i = 0; i < 4; i++) begin
                chk("R8 req_ready low while busy", {31'b0, req_ready}, 32'd0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        for (int i = 0; i < 200 && !rsp_valid; i++) @(negedge clk);
    endtask

    task automatic ack_walk();
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_tb();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
        chk("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            vec_t e = VECS[v];
            run_walk(e.va, 1'b0);
            chk("R9 rsp_valid", {31'b0, rsp_valid}, 32'd1);
            chk(e.fault ? (e.lvl == 2'b01 ? "R6 fault" : "R7 fault") : "R5 fault",
                {31'b0, rsp_fault}, {31'b0, e.fault});
            chk(e.fault ? (e.lvl == 2'b01 ? "R6 level" : "R7 level") : "R5 level",
                {30'b0, rsp_level}, {30'b0, e.lvl});
            chk(e.fault ? "R6 R7 read count" : "R5 read count",
                {28'b0, walk_reads}, {28'b0, e.reads});
            chk("R3 master entry address", rd_addr0, {ROOT, e.va[31:22], 2'b00});
            if (e.reads == 4'd2)
                chk("R4 secondary entry address", rd_addr1,
                    e.sec_frame_base | {20'b0, e.va[21:12], 2'b00});
            if (!e.fault) begin
                chk("R5 physical address", rsp_paddr, e.pa);
                chk("R2 offset passthrough", {20'b0, rsp_paddr[11:0]}, {20'b0, e.va[11:0]});
            end
            ack_walk();
        end

        // R8: stray request during a walk is ignored
        run_walk(32'h0040_5123, 1'b1);
        chk("R8 result unchanged by stray", rsp_paddr, 32'hABCD_E123);
        chk("R8 read count", {28'b0, walk_reads}, 32'd2);

        // R9: response held until acknowledged
        repeat (5) @(negedge clk);
        chk("R9 rsp_valid held", {31'b0, rsp_valid}, 32'd1);
        chk("R9 paddr held", rsp_paddr, 32'hABCD_E123);
        ack_walk();
        chk("R9 rsp_valid dropped", {31'b0, rsp_valid}, 32'd0);
        chk("R9 back to idle", {31'b0, req_ready}, 32'd1);

        // R10: memory back-pressure
        stall_en = 1'b1;
        run_walk(32'h007F_FFFF, 1'b0);
        chk("R10 paddr under stall", rsp_paddr, 32'h1234_5FFF);
        chk("R10 read count under stall", {28'b0, walk_reads}, 32'd2);
        chk("R10 master address under stall", rd_addr0, 32'h0001_0004);
        chk("R10 secondary address under stall", rd_addr1, 32'h0002_0FFC);
        ack_walk();
        run_walk(32'h0040_6777, 1'b1);
        chk("R7 fault under stall", {30'b0, rsp_level}, 32'd2);
        ack_walk();
        stall_en = 1'b0;

        repeat (2) @(negedge clk);
        finish_tb();
    end
endmodule